// File: doc/BRIEF.md
# DMA Control Register Block with Gated Interrupt

This block is the word-wide register front end of a byte-serial DMA channel. It serves a storage controller that reports command and transfer completion. Software reaches it through a simple write port and a combinational read port. It holds four or more 32-bit registers: a control/status word, a DMA byte address, a byte count and spare storage. The control word carries the transfer direction, an interrupt enable, a sticky interrupt-pending flag, a loaded flag and a version code. Writing the control word with one of two action bits set triggers an action and does not store the value.

Each completion pulse from the controller latches the pending flag. The interrupt line is the pending flag gated by the enable bit. The bus master that moves the data is outside this block. The block only gives it the current byte address, the direction and a byte strobe. The address advances by one for every beat the master accepts.

Top module: `dma_gate_ctl`

## Requirements
- R1: After reset every register reads 0x00000000, and `irq` and `mem_dir` are low.
- R2: The register index is (`bus_addr` AND (4*NREGS-1)) >> 2. Index 0 is control, 1 is address, 2 is count, and higher indices are spare. With NREGS=4, bus addresses 0x14 and 0x04 both select the address register.
- R3: A control write with bits 7 and 6 clear stores the written word as given, except for bit 0. The address, count and spare registers store any written word unchanged.
- R4: A pulse on `cmd_done` sets control bit 0, the pending flag, in the following cycle. The flag then stays set until software clears it.
- R5: A control write with bit 0 set clears the pending flag. With bit 0 clear, the write leaves the flag unchanged. A `cmd_done` pulse in the same cycle as the clearing write wins, and the flag stays set.
- R6: `irq` equals the pending flag AND control bit 4, the enable. A control write with bit 4 clear drives `irq` low in the cycle after the write.
- R7: A control write with bit 7 set loads the control word with 0xA4000000, which is loaded bit 26 plus the version code 0xA0000000. The pending flag ends clear. Bit 7 takes priority over bit 6.
- R8: A control write with bit 6 set and bit 7 clear clears the pending flag and leaves every other control bit unchanged.
- R9: `mem_dir` follows control bit 8: 1 means device to memory, 0 means memory to device.
- R10: `mem_stb` equals `beat_req`. The address register increments by one, wrapping at 32 bits, on each cycle where `beat_req` and `beat_ack` are both high. In any other cycle without a write it holds.
- R11: A bus write to the address register in the same cycle as an accepted beat stores the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmd_done | input | 1 | Completion pulse from the controller |
| beat_req | input | 1 | Controller wants one byte moved |
| beat_ack | input | 1 | Bus master accepted the byte |
| mem_addr | output | 32 | Current DMA byte address |
| mem_dir | output | 1 | Transfer direction (1 = into memory) |
| mem_stb | output | 1 | Byte strobe to the bus master |
| irq | output | 1 | Gated interrupt request |

## Verification
Register writes, completion pulses and accepted beats all take effect at the next rising edge. The bench therefore drives each stimulus after a falling edge and removes it after the following falling edge, so exactly one rising edge falls between them. It reads the result back through the combinational read port a little after that second falling edge. `irq` and `mem_dir` come from registered state and are due in that same cycle. `mem_stb` is combinational and is sampled within the cycle in which `beat_req` is driven.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_ADDR = 1;
   localparam int unsigned IDX_CNT  = 2;

   typedef enum logic [1:0] {
      CW_KEEP  = 2'd0,
      CW_STORE = 2'd1,
      CW_FLUSH = 2'd2,
      CW_RESET = 2'd3
   } ctrl_act_e;

   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
   import dma_gate_pkg::*;
#(
   parameter int unsigned PEND_BIT  = 0,
   parameter int unsigned EN_BIT    = 4,
   parameter int unsigned FLUSH_BIT = 6,
   parameter int unsigned RST_BIT   = 7,
   parameter int unsigned LOAD_BIT  = 26,
   parameter word_t       VERSION   = 32'hA000_0000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr,
   input  word_t wdata,
   input  logic  done,
   output word_t ctrl_q,
   output logic  irq
);
   localparam word_t RELOAD = VERSION | (word_t'(1) << LOAD_BIT);

   ctrl_act_e act;
   word_t     ctrl_n;

   always_comb begin
      if (!wr)                  act = CW_KEEP;
      else if (wdata[RST_BIT])  act = CW_RESET;
      else if (wdata[FLUSH_BIT]) act = CW_FLUSH;
      else                      act = CW_STORE;
   end

   always_comb begin
      ctrl_n = ctrl_q;
      unique case (act)
         CW_RESET: ctrl_n = RELOAD;
         CW_FLUSH: ctrl_n[PEND_BIT] = 1'b0;
         CW_STORE: begin
            ctrl_n           = wdata;
            ctrl_n[PEND_BIT] = ctrl_q[PEND_BIT] & ~wdata[PEND_BIT];
         end
         default: ctrl_n = ctrl_q;
      endcase
      if (done) ctrl_n[PEND_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_n;
   end

   assign irq = ctrl_q[PEND_BIT] & ctrl_q[EN_BIT];
endmodule

// File: rtl/dma_gate_ptr.sv
module dma_gate_ptr #(
   parameter int unsigned PTR_W = 32,
   parameter int unsigned STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [PTR_W-1:0] wdata,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr_q
);
   localparam logic [PTR_W-1:0] INC = PTR_W'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (wr)  ptr_q <= wdata;
      else if (adv) ptr_q <= ptr_q + INC;
   end
endmodule

// File: rtl/dma_gate_aux.sv
module dma_gate_aux #(
   parameter int unsigned NAUX = 2,
   parameter int unsigned DW   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NAUX-1:0]          wr,
   input  logic [DW-1:0]            wdata,
   output logic [NAUX-1:0][DW-1:0]  regs_q
);
   for (genvar g = 0; g < NAUX; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)     regs_q[g] <= '0;
         else if (wr[g]) regs_q[g] <= wdata;
      end
   end
endmodule

// File: rtl/dma_gate_ctl.sv
module dma_gate_ctl
   import dma_gate_pkg::*;
#(
   parameter int unsigned NREGS     = 4,
   parameter int unsigned BUS_AW    = 8,
   parameter int unsigned PEND_BIT  = 0,
   parameter int unsigned EN_BIT    = 4,
   parameter int unsigned FLUSH_BIT = 6,
   parameter int unsigned RST_BIT   = 7,
   parameter int unsigned DIR_BIT   = 8,
   parameter int unsigned LOAD_BIT  = 26,
   parameter logic [31:0] VERSION   = 32'hA000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              cmd_done,
   input  logic              beat_req,
   input  logic              beat_ack,
   output logic [31:0]       mem_addr,
   output logic              mem_dir,
   output logic              mem_stb,
   output logic              irq
);
   localparam int unsigned IDX_W = $clog2(NREGS);
   localparam int unsigned IDX_H = IDX_W + 1;
   localparam int unsigned NAUX  = NREGS - 2;

   if (NREGS < 3 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two of at least 4");
   end
   if (BUS_AW < IDX_H + 1) begin : g_bad_aw
      $error("BUS_AW too narrow for NREGS");
   end
   if (PEND_BIT == EN_BIT || FLUSH_BIT == RST_BIT || PEND_BIT == RST_BIT ||
       PEND_BIT == FLUSH_BIT || DIR_BIT >= WORD_W || LOAD_BIT >= WORD_W) begin : g_bad_bits
      $error("control bit positions overlap or exceed the word");
   end

   logic [IDX_W-1:0]     idx;
   logic                 wr_ctrl, wr_addr;
   logic [NAUX-1:0]      wr_aux;
   word_t                ctrl_q;
   logic [NAUX-1:0][31:0] aux_q;
   logic                 step;

   assign idx     = bus_addr[IDX_H:2];
   assign wr_ctrl = bus_wr && (idx == IDX_W'(IDX_CTRL));
   assign wr_addr = bus_wr && (idx == IDX_W'(IDX_ADDR));
   assign step    = beat_req && beat_ack;

   for (genvar g = 0; g < NAUX; g++) begin : g_auxsel
      assign wr_aux[g] = bus_wr && (idx == IDX_W'(g + IDX_CNT));
   end

   dma_gate_ctrl #(
      .PEND_BIT (PEND_BIT),
      .EN_BIT   (EN_BIT),
      .FLUSH_BIT(FLUSH_BIT),
      .RST_BIT  (RST_BIT),
      .LOAD_BIT (LOAD_BIT),
      .VERSION  (VERSION)
   ) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctrl),
      .wdata (bus_wdata),
      .done  (cmd_done),
      .ctrl_q(ctrl_q),
      .irq   (irq)
   );

   dma_gate_ptr #(
      .PTR_W(32),
      .STEP (1)
   ) i_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_addr),
      .wdata(bus_wdata),
      .adv  (step),
      .ptr_q(mem_addr)
   );

   dma_gate_aux #(
      .NAUX(NAUX),
      .DW  (32)
   ) i_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_aux),
      .wdata (bus_wdata),
      .regs_q(aux_q)
   );

   always_comb begin
      if (idx == IDX_W'(IDX_CTRL))      bus_rdata = ctrl_q;
      else if (idx == IDX_W'(IDX_ADDR)) bus_rdata = mem_addr;
      else                              bus_rdata = aux_q[idx - IDX_W'(IDX_CNT)];
   end

   assign mem_dir = ctrl_q[DIR_BIT];
   assign mem_stb = beat_req;
endmodule

// File: rtl/dma_gate_ctl_chk.sv
module dma_gate_ctl_chk #(
   parameter int unsigned PEND_BIT  = 0,
   parameter int unsigned EN_BIT    = 4,
   parameter int unsigned FLUSH_BIT = 6,
   parameter int unsigned RST_BIT   = 7,
   parameter int unsigned DIR_BIT   = 8,
   parameter int unsigned LOAD_BIT  = 26,
   parameter logic [31:0] VERSION   = 32'hA000_0000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_ctrl,
   input logic        wr_addr,
   input logic [31:0] bus_wdata,
   input logic        cmd_done,
   input logic        beat_req,
   input logic        beat_ack,
   input logic [31:0] ctrl_q,
   input logic [31:0] mem_addr,
   input logic        mem_dir,
   input logic        irq
);
   localparam logic [31:0] RELOAD  = VERSION | (32'd1 << LOAD_BIT);
   localparam logic [31:0] NOPEND  = ~(32'd1 << PEND_BIT);

   logic plain_wr;
   assign plain_wr = wr_ctrl && !bus_wdata[RST_BIT] && !bus_wdata[FLUSH_BIT];

   p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> ctrl_q[PEND_BIT]);

   p_pend_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_wr && bus_wdata[PEND_BIT] && !cmd_done) |=> !ctrl_q[PEND_BIT]);

   p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_wr && !bus_wdata[EN_BIT]) |=> !irq);

   p_swreset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[RST_BIT] && !cmd_done) |=> (ctrl_q == RELOAD));

   p_flush_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[FLUSH_BIT] && !bus_wdata[RST_BIT])
      |=> ((ctrl_q & NOPEND) == ($past(ctrl_q) & NOPEND)));

   p_dir_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      plain_wr |=> (mem_dir == $past(bus_wdata[DIR_BIT])));

   p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && beat_ack && !wr_addr) |=> (mem_addr == $past(mem_addr) + 32'd1));

   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(beat_req && beat_ack) && !wr_addr) |=> $stable(mem_addr));

   p_addr_wrwin_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_addr |=> (mem_addr == $past(bus_wdata)));
endmodule

bind dma_gate_ctl dma_gate_ctl_chk #(
   .PEND_BIT (PEND_BIT),
   .EN_BIT   (EN_BIT),
   .FLUSH_BIT(FLUSH_BIT),
   .RST_BIT  (RST_BIT),
   .DIR_BIT  (DIR_BIT),
   .LOAD_BIT (LOAD_BIT),
   .VERSION  (VERSION)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_ctrl  (wr_ctrl),
   .wr_addr  (wr_addr),
   .bus_wdata(bus_wdata),
   .cmd_done (cmd_done),
   .beat_req (beat_req),
   .beat_ack (beat_ack),
   .ctrl_q   (ctrl_q),
   .mem_addr (mem_addr),
   .mem_dir  (mem_dir),
   .irq      (irq)
);

// File: tb/test_dma_gate_ctl.sv
`timescale 1ns/1ps
module test_dma_gate_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cmd_done = 1'b0;
   logic        beat_req = 1'b0;
   logic        beat_ack = 1'b0;
   logic [31:0] mem_addr;
   logic        mem_dir, mem_stb, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dma_gate_ctl i_dma_gate_ctl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_done(cmd_done),
      .beat_req(beat_req), .beat_ack(beat_ack), .mem_addr(mem_addr),
      .mem_dir(mem_dir), .mem_stb(mem_stb), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic done_pulse();
      @(negedge clk); cmd_done = 1'b1;
      @(negedge clk); cmd_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         bread(8'(i * 4), v);
         check("R1 reg after reset", v, 32'h0);
      end
      check("R1 irq after reset", {31'd0, irq}, 32'h0);
      check("R1 dir after reset", {31'd0, mem_dir}, 32'h0);
   endtask

   task automatic t_store();
      logic [31:0] v;
      bwrite(8'h08, 32'h1234_5678);
      bwrite(8'h0C, 32'hDEAD_BEEF);
      bwrite(8'h00, 32'h5A5A_0E30 & ~32'hC1);
      bread(8'h08, v); check("R3 count store", v, 32'h1234_5678);
      bread(8'h0C, v); check("R3 spare store", v, 32'hDEAD_BEEF);
      bread(8'h00, v); check("R3 ctrl store", v, 32'h5A5A_0E30);
      bwrite(8'h00, 32'h0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      bwrite(8'h14, 32'hCAFE_0001);
      bread(8'h04, v); check("R2 alias 0x14 -> address", v, 32'hCAFE_0001);
      bread(8'hF8, v); check("R2 alias 0xF8 -> count", v, 32'h1234_5678);
   endtask

   task automatic t_pending();
      logic [31:0] v;
      bwrite(8'h00, 32'h0);
      done_pulse();
      bread(8'h00, v); check("R4 pending set", v & 32'h1, 32'h1);
      check("R6 irq masked while enable clear", {31'd0, irq}, 32'h0);
      @(negedge clk);
      bread(8'h00, v); check("R4 pending sticky", v & 32'h1, 32'h1);
      bwrite(8'h00, 32'h10);
      bread(8'h00, v); check("R5 write 0 keeps pending", v & 32'h1, 32'h1);
      check("R6 irq pending and enabled", {31'd0, irq}, 32'h1);
      bwrite(8'h00, 32'h11);
      bread(8'h00, v); check("R5 W1C clears pending", v & 32'h1, 32'h0);
      check("R6 irq low after clear", {31'd0, irq}, 32'h0);
      done_pulse();
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h11; cmd_done = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cmd_done = 1'b0;
      bread(8'h00, v); check("R5 done wins over clear", v & 32'h1, 32'h1);
      bwrite(8'h00, 32'h0);
      check("R6 enable clear drops irq", {31'd0, irq}, 32'h0);
      bread(8'h00, v); check("R6 pending kept while masked", v & 32'h1, 32'h1);
   endtask

   task automatic t_actions();
      logic [31:0] v;
      bwrite(8'h00, 32'h0000_0110);
      done_pulse();
      check("R6 irq up before flush", {31'd0, irq}, 32'h1);
      bwrite(8'h00, 32'h0000_0040);
      bread(8'h00, v); check("R8 flush keeps other bits", v, 32'h0000_0110);
      check("R8 flush drops irq", {31'd0, irq}, 32'h0);
      done_pulse();
      bwrite(8'h00, 32'h0000_00C0);
      bread(8'h00, v); check("R7 soft reset value", v, 32'hA400_0000);
      check("R7 irq low after soft reset", {31'd0, irq}, 32'h0);
      check("R9 dir cleared by soft reset", {31'd0, mem_dir}, 32'h0);
   endtask

   task automatic t_dir();
      bwrite(8'h00, 32'h0000_0100);
      check("R9 dir set", {31'd0, mem_dir}, 32'h1);
      bwrite(8'h00, 32'h0000_0000);
      check("R9 dir clear", {31'd0, mem_dir}, 32'h0);
   endtask

   task automatic beats(input int n, input logic ack);
      @(negedge clk);
      beat_req = 1'b1; beat_ack = ack;
      #0.5;
      check("R10 strobe follows request", {31'd0, mem_stb}, 32'h1);
      for (int i = 1; i < n; i++) @(negedge clk);
      @(negedge clk);
      beat_req = 1'b0; beat_ack = 1'b0;
   endtask

   task automatic t_beats();
      logic [31:0] v;
      bwrite(8'h04, 32'h0000_1000);
      beats(5, 1'b1);
      bread(8'h04, v); check("R10 five beats", v, 32'h0000_1005);
      check("R10 strobe low when idle", {31'd0, mem_stb}, 32'h0);
      beats(3, 1'b0);
      bread(8'h04, v); check("R10 no ack no step", v, 32'h0000_1005);
      @(negedge clk); beat_ack = 1'b1;
      @(negedge clk); beat_ack = 1'b0;
      bread(8'h04, v); check("R10 ack without request", v, 32'h0000_1005);
      bwrite(8'h04, 32'hFFFF_FFFF);
      beats(2, 1'b1);
      bread(8'h04, v); check("R10 wrap", v, 32'h0000_0001);
      check("R10 mem_addr port", mem_addr, 32'h0000_0001);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      @(negedge clk);
      beat_req = 1'b1; beat_ack = 1'b1;
      bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_4000;
      @(negedge clk);
      bus_wr = 1'b0; beat_req = 1'b0; beat_ack = 1'b0;
      bread(8'h04, v); check("R11 write wins over beat", v, 32'h0000_4000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_store();
      t_decode();
      t_pending();
      t_actions();
      t_dir();
      t_beats();
      t_collide();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule